// File: doc/BRIEF.md
# Dual-Credit Look-Ahead Port Scheduler

This block chooses which transmit port may send next on a channelized packet link. Each of its ports raises a request line when it holds data. The far end reports its receive fill level per port over a status path. A small lookup table turns each reported fill level into a credit amount. The scheduler keeps one credit register per port. A port is eligible when it requests and its credit register is non-zero.

The scheduler always keeps two grants ready: the current grant, which is the port now sending, and a prepared next grant. When the scheduler is idle, one arbitration step fills both grants in the same clock edge. When the framer reports the end of a burst, the prepared next grant becomes the current grant on that edge. A new next grant is chosen on the same edge. The transmitter therefore never waits for a full round of status updates between two back-to-back bursts. Every grant clears the granted port's credit. Selection is round robin among eligible ports and starts after the port granted most recently.

Top module: `dual_credit_sched`

## Requirements
- R1: After reset, both grants are invalid, both credit outputs are zero and every port's credit is zero. Requests alone then produce no grant.
- R2: A status update for one port loads that port's credit from a table. The 2-bit fill code maps as follows: 2'b00 (starving) gives STARVE_CREDIT (default 64), 2'b01 (hungry) gives HUNGRY_CREDIT (default 16), and 2'b10 and 2'b11 give zero. The new value counts for arbitration from the next cycle.
- R3: A port is eligible only while its request is high and its credit is non-zero. Granting a port clears its credit. A status update for the same port in the same cycle takes precedence and leaves the updated value.
- R4: When no current grant is held, one step selects the current port round robin, starting after the last granted port. The same step selects the next port round robin, starting after that current port. Both grants appear after the same clock edge.
- R5: While a current grant is held and no next grant is held, the next port is chosen round robin starting after the last granted port. It is never the current port.
- R6: A burst-done pulse while a current grant is held moves the next grant, with its port and credit, into the current grant after that edge. A new next grant is chosen on that same edge.
- R7: Without a burst-done pulse, a valid current grant keeps its port and credit.
- R8: If no port other than the current one is eligible, the next grant is invalid. A burst-done pulse then leaves no current grant, unless some port is eligible on that same cycle.
- R9: A burst-done pulse while no current grant is held has no effect beyond normal arbitration.
- R10: Each grant carries the credit that its port held at the moment it was granted. This credit is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NP | Per-port request lines |
| stat_valid_i | input | 1 | Status update strobe |
| stat_port_i | input | PW | Port addressed by the status update |
| stat_code_i | input | 2 | Fill code of the addressed port |
| burst_done_i | input | 1 | End of the current burst |
| cur_valid_o | output | 1 | Current grant valid |
| cur_port_o | output | PW | Current granted port |
| cur_credit_o | output | CW | Credit assigned to the current grant |
| nxt_valid_o | output | 1 | Prepared next grant valid |
| nxt_port_o | output | PW | Prepared next port |
| nxt_credit_o | output | CW | Credit assigned to the prepared next grant |

## Verification
The assertions check, on every cycle, the following properties:
- The two grants never name the same port.
- A next grant never exists without a current grant.
- The current grant holds steady between burst-done pulses.
- A burst-done pulse moves the next grant into the current grant with its credit intact.
- Every grant carries non-zero credit.

Only the bench scenarios can show the rest:
- The order in which round robin visits the ports.
- The credit values produced by the fill-code table.
- Precedence of a status update over a same-cycle clear.
- Two grants filled together from idle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    // Fill level reported per port over the status path
    typedef enum logic [1:0] {
        FILL_STARVING  = 2'b00,
        FILL_HUNGRY    = 2'b01,
        FILL_SATISFIED = 2'b10,
        FILL_RESERVED  = 2'b11
    } fill_code_e;

endpackage

// File: rtl/dcs_credit_table.sv
module dcs_credit_table
    import dcs_pkg::*;
#(
    parameter int NP            = 32,
    parameter int CW            = 8,
    parameter int STARVE_CREDIT = 64,
    parameter int HUNGRY_CREDIT = 16,
    localparam int PW           = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_valid_i,
    input  logic [PW-1:0]          upd_port_i,
    input  logic [1:0]             upd_code_i,
    input  logic [NP-1:0]          clr_mask_i,
    output logic [NP-1:0][CW-1:0]  credit_o
);

    // Lookup table indexed by the fill code, entry 0 in the low bits
    localparam logic [4*CW-1:0] CREDIT_LUT = {
        {CW{1'b0}},
        {CW{1'b0}},
        CW'(HUNGRY_CREDIT),
        CW'(STARVE_CREDIT)
    };

    logic [NP-1:0][CW-1:0] cr_d, cr_q;
    logic [CW-1:0]         lut_val;

    always_comb begin
        lut_val = CREDIT_LUT[int'(upd_code_i)*CW +: CW];
    end

    always_comb begin
        cr_d = cr_q;
        for (int i = 0; i < NP; i++) begin
            if (clr_mask_i[i]) begin
                cr_d[i] = '0;
            end
            // a fresh update for the same port wins over the grant clear
            if (upd_valid_i && (upd_port_i == PW'(i))) begin
                cr_d[i] = lut_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign credit_o = cr_q;

endmodule

// File: rtl/dcs_rr_pick.sv
module dcs_rr_pick #(
    parameter int NP  = 32,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] mask_i,
    input  logic [PW-1:0] last_i,
    output logic          found_o,
    output logic [PW-1:0] idx_o
);

    int j;

    // first set bit strictly after last_i, wrapping, last_i itself tried last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        j       = 0;
        for (int k = 1; k <= NP; k++) begin
            j = int'(last_i) + k;
            if (j >= NP) begin
                j = j - NP;
            end
            if (!found_o && mask_i[j]) begin
                found_o = 1'b1;
                idx_o   = PW'(j);
            end
        end
    end

endmodule

// File: rtl/dual_credit_sched.sv
module dual_credit_sched
    import dcs_pkg::*;
#(
    parameter int NP            = 32,
    parameter int CW            = 8,
    parameter int STARVE_CREDIT = 64,
    parameter int HUNGRY_CREDIT = 16,
    localparam int PW           = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req_i,
    input  logic          stat_valid_i,
    input  logic [PW-1:0] stat_port_i,
    input  logic [1:0]    stat_code_i,
    input  logic          burst_done_i,
    output logic          cur_valid_o,
    output logic [PW-1:0] cur_port_o,
    output logic [CW-1:0] cur_credit_o,
    output logic          nxt_valid_o,
    output logic [PW-1:0] nxt_port_o,
    output logic [CW-1:0] nxt_credit_o
);

    typedef struct packed {
        logic          cur_v;
        logic [PW-1:0] cur_p;
        logic [CW-1:0] cur_cr;
        logic          nxt_v;
        logic [PW-1:0] nxt_p;
        logic [CW-1:0] nxt_cr;
        logic [PW-1:0] last;
    } sched_t;

    sched_t s_d, s_q;

    logic [NP-1:0][CW-1:0] credit;
    logic [NP-1:0]         elig;
    logic [NP-1:0]         clr_mask;

    // slots after a possible promotion
    logic                  promote;
    logic                  pc_v;
    logic [PW-1:0]         pc_p;
    logic [CW-1:0]         pc_cr;
    logic                  pn_v;

    logic                  a_found, b_found;
    logic [PW-1:0]         a_idx, b_idx;
    logic [NP-1:0]         b_mask;
    logic [PW-1:0]         b_base;

    dcs_credit_table #(
        .NP            (NP),
        .CW            (CW),
        .STARVE_CREDIT (STARVE_CREDIT),
        .HUNGRY_CREDIT (HUNGRY_CREDIT)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid_i (stat_valid_i),
        .upd_port_i  (stat_port_i),
        .upd_code_i  (stat_code_i),
        .clr_mask_i  (clr_mask),
        .credit_o    (credit)
    );

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            elig[i] = req_i[i] && (credit[i] != '0);
        end
    end

    always_comb begin
        promote = burst_done_i && s_q.cur_v;
        pc_v    = promote ? s_q.nxt_v  : s_q.cur_v;
        pc_p    = promote ? s_q.nxt_p  : s_q.cur_p;
        pc_cr   = promote ? s_q.nxt_cr : s_q.cur_cr;
        pn_v    = promote ? 1'b0       : s_q.nxt_v;
    end

    // first pick: current slot when it is empty
    dcs_rr_pick #(.NP(NP)) u_pick_cur (
        .mask_i  (elig),
        .last_i  (s_q.last),
        .found_o (a_found),
        .idx_o   (a_idx)
    );

    always_comb begin
        b_mask = elig;
        if (pc_v) begin
            b_mask[pc_p] = 1'b0;
            b_base       = s_q.last;
        end else begin
            if (a_found) begin
                b_mask[a_idx] = 1'b0;
            end
            b_base = a_idx;
        end
    end

    // second pick: next slot, chained after the first
    dcs_rr_pick #(.NP(NP)) u_pick_nxt (
        .mask_i  (b_mask),
        .last_i  (b_base),
        .found_o (b_found),
        .idx_o   (b_idx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cur_v  = pc_v;
        s_d.cur_p  = pc_p;
        s_d.cur_cr = pc_cr;
        s_d.nxt_v  = pn_v;
        if (!pn_v) begin
            s_d.nxt_cr = '0;
        end
        if (!pc_v) begin
            s_d.cur_cr = '0;
        end
        clr_mask = '0;
        if (!pc_v) begin
            if (a_found) begin
                s_d.cur_v       = 1'b1;
                s_d.cur_p       = a_idx;
                s_d.cur_cr      = credit[a_idx];
                s_d.last        = a_idx;
                clr_mask[a_idx] = 1'b1;
            end
            if (a_found && b_found) begin
                s_d.nxt_v       = 1'b1;
                s_d.nxt_p       = b_idx;
                s_d.nxt_cr      = credit[b_idx];
                s_d.last        = b_idx;
                clr_mask[b_idx] = 1'b1;
            end
        end else if (!pn_v) begin
            if (b_found) begin
                s_d.nxt_v       = 1'b1;
                s_d.nxt_p       = b_idx;
                s_d.nxt_cr      = credit[b_idx];
                s_d.last        = b_idx;
                clr_mask[b_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cur_v  <= 1'b0;
            s_q.cur_p  <= '0;
            s_q.cur_cr <= '0;
            s_q.nxt_v  <= 1'b0;
            s_q.nxt_p  <= '0;
            s_q.nxt_cr <= '0;
            s_q.last   <= PW'(NP - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_valid_o  = s_q.cur_v;
    assign cur_port_o   = s_q.cur_p;
    assign cur_credit_o = s_q.cur_cr;
    assign nxt_valid_o  = s_q.nxt_v;
    assign nxt_port_o   = s_q.nxt_p;
    assign nxt_credit_o = s_q.nxt_cr;

endmodule

// File: rtl/dcs_sched_chk.sv
module dcs_sched_chk #(
    parameter int NP  = 32,
    parameter int CW  = 8,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] req_i,
    input logic          stat_valid_i,
    input logic [PW-1:0] stat_port_i,
    input logic [1:0]    stat_code_i,
    input logic          burst_done_i,
    input logic          cur_valid_o,
    input logic [PW-1:0] cur_port_o,
    input logic [CW-1:0] cur_credit_o,
    input logic          nxt_valid_o,
    input logic [PW-1:0] nxt_port_o,
    input logic [CW-1:0] nxt_credit_o
);

    a_r5_grants_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid_o && nxt_valid_o) |-> (cur_port_o != nxt_port_o));

    a_r8_next_needs_current: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_valid_o |-> cur_valid_o);

    a_r6_promotion: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done_i && cur_valid_o && nxt_valid_o) |=>
        (cur_valid_o && cur_port_o == $past(nxt_port_o) &&
         cur_credit_o == $past(nxt_credit_o)));

    a_r7_hold_current: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_done_i && cur_valid_o) |=>
        (cur_valid_o && $stable(cur_port_o) && $stable(cur_credit_o)));

    a_r10_cur_credit_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o |-> (cur_credit_o != '0));

    a_r10_nxt_credit_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_valid_o |-> (nxt_credit_o != '0));

    a_r3_no_request_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_valid_o && (req_i == '0)) |=> !cur_valid_o);

endmodule

bind dual_credit_sched dcs_sched_chk #(.NP(NP), .CW(CW)) u_chk (.*);

// File: tb/dual_credit_sched_test.sv
module dual_credit_sched_test;

    localparam int NP = 32;
    localparam int CW = 8;
    localparam int PW = 5;
    localparam int STARVE = 64;
    localparam int HUNGRY = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] req_i = '0;
    logic          stat_valid_i = 1'b0;
    logic [PW-1:0] stat_port_i = '0;
    logic [1:0]    stat_code_i = '0;
    logic          burst_done_i = 1'b0;
    logic          cur_valid_o, nxt_valid_o;
    logic [PW-1:0] cur_port_o, nxt_port_o;
    logic [CW-1:0] cur_credit_o, nxt_credit_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_cr [NP];
    bit m_cv, m_nv;
    int m_cp, m_np, m_ccr, m_ncr, m_last;

    always #10 clk = ~clk;

    dual_credit_sched #(.NP(NP), .CW(CW), .STARVE_CREDIT(STARVE),
                        .HUNGRY_CREDIT(HUNGRY)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .stat_valid_i(stat_valid_i),
        .stat_port_i(stat_port_i), .stat_code_i(stat_code_i),
        .burst_done_i(burst_done_i), .cur_valid_o(cur_valid_o),
        .cur_port_o(cur_port_o), .cur_credit_o(cur_credit_o),
        .nxt_valid_o(nxt_valid_o), .nxt_port_o(nxt_port_o),
        .nxt_credit_o(nxt_credit_o)
    );

    function automatic int lut(input int code);
        case (code)
            0: return STARVE;
            1: return HUNGRY;
            default: return 0;
        endcase
    endfunction

    function automatic int pick(input bit [NP-1:0] m, input int last);
        for (int k = 1; k <= NP; k++) begin
            int j = (last + k) % NP;
            if (m[j]) return j;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NP; i++) m_cr[i] = 0;
        m_cv = 0; m_nv = 0; m_cp = 0; m_np = 0; m_ccr = 0; m_ncr = 0;
        m_last = NP - 1;
    endtask

    task automatic model_step(input bit [NP-1:0] rq, input bit sv, input int sp,
                              input int sc, input bit bd);
        bit [NP-1:0] el;
        int nc [NP];
        int a, b;
        bit cv, nv;
        int cp, ccr;
        cv = (bd && m_cv) ? m_nv : m_cv;
        cp = (bd && m_cv) ? m_np : m_cp;
        ccr = (bd && m_cv) ? m_ncr : m_ccr;
        nv = (bd && m_cv) ? 1'b0 : m_nv;
        for (int i = 0; i < NP; i++) begin
            el[i] = rq[i] && (m_cr[i] != 0);
            nc[i] = m_cr[i];
        end
        if (!cv) begin
            ccr = 0;
            a = pick(el, m_last);
            if (a >= 0) begin
                cv = 1; cp = a; ccr = m_cr[a]; nc[a] = 0; m_last = a; el[a] = 1'b0;
                b = pick(el, a);
                if (b >= 0) begin
                    nv = 1; m_np = b; m_ncr = m_cr[b]; nc[b] = 0; m_last = b;
                end
            end
        end else if (!nv) begin
            el[cp] = 1'b0;
            b = pick(el, m_last);
            if (b >= 0) begin
                nv = 1; m_np = b; m_ncr = m_cr[b]; nc[b] = 0; m_last = b;
            end
        end
        if (!nv) m_ncr = 0;
        if (sv) nc[sp] = lut(sc);
        for (int i = 0; i < NP; i++) m_cr[i] = nc[i];
        m_cv = cv; m_cp = cp; m_ccr = ccr; m_nv = nv;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one cycle (called just after a falling edge), then sample at next falling edge
    task automatic tick(input bit [NP-1:0] rq, input bit sv, input int sp,
                        input int sc, input bit bd);
        req_i = rq; stat_valid_i = sv; stat_port_i = PW'(sp);
        stat_code_i = 2'(sc); burst_done_i = bd;
        model_step(rq, sv, sp, sc, bd);
        @(negedge clk);
        check(cur_valid_o == m_cv && (!m_cv || int'(cur_port_o) == m_cp), "R6",
              "current port", cur_valid_o ? int'(cur_port_o) : -1, m_cv ? m_cp : -1);
        check(nxt_valid_o == m_nv && (!m_nv || int'(nxt_port_o) == m_np), "R5",
              "next port", nxt_valid_o ? int'(nxt_port_o) : -1, m_nv ? m_np : -1);
        check(int'(cur_credit_o) == m_ccr && int'(nxt_credit_o) == (m_nv ? m_ncr : 0),
              "R10", "grant credit", int'(cur_credit_o), m_ccr);
    endtask

    function automatic bit [NP-1:0] bits3(input int x, input int y, input int z);
        bit [NP-1:0] r = '0;
        r[x] = 1'b1; r[y] = 1'b1; r[z] = 1'b1;
        return r;
    endfunction

    initial begin
        #(2_000_000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        check(!cur_valid_o && !nxt_valid_o && cur_credit_o == 0 && nxt_credit_o == 0,
              "R1", "reset outputs", int'(cur_valid_o), 0);
        rst_n = 1'b1;

        // R1: no credits yet, requests give no grant
        tick('1, 0, 0, 0, 0);
        check(!cur_valid_o, "R1", "grant without credit", int'(cur_valid_o), 0);

        // R2: load table values for ports 3, 7, 9
        tick('0, 1, 3, 0, 0);
        tick('0, 1, 7, 1, 0);
        tick('0, 1, 9, 2, 0);
        // R4: idle step grants two ports at once
        tick(bits3(3, 7, 9), 0, 0, 0, 0);
        check(cur_valid_o && cur_port_o == 3 && cur_credit_o == STARVE, "R4",
              "idle current", int'(cur_port_o), 3);
        check(nxt_valid_o && nxt_port_o == 7 && nxt_credit_o == HUNGRY, "R2",
              "hungry credit", int'(nxt_credit_o), HUNGRY);
        // R7: hold
        tick(bits3(3, 7, 9), 0, 0, 0, 0);
        check(cur_valid_o && cur_port_o == 3, "R7", "hold current", int'(cur_port_o), 3);
        // R6/R8: promote; port 9 (code 2'b10) has zero credit so no next
        tick(bits3(3, 7, 9), 0, 0, 0, 1);
        check(cur_valid_o && cur_port_o == 7 && cur_credit_o == HUNGRY, "R6",
              "promoted current", int'(cur_port_o), 7);
        check(!nxt_valid_o, "R8", "next with nobody eligible", int'(nxt_valid_o), 0);
        tick(bits3(3, 7, 9), 0, 0, 0, 1);
        check(!cur_valid_o, "R8", "pause after last burst", int'(cur_valid_o), 0);
        // R9: burst-done with no grant
        tick('0, 0, 0, 0, 1);
        check(!cur_valid_o && !nxt_valid_o, "R9", "done while idle", int'(cur_valid_o), 0);

        // R3: same-cycle update wins over grant clear
        tick('0, 1, 3, 0, 0);
        tick(bits3(3, 3, 3), 1, 3, 1, 0);
        check(cur_valid_o && cur_port_o == 3 && cur_credit_o == STARVE, "R3",
              "grant with old credit", int'(cur_credit_o), STARVE);
        tick(bits3(3, 3, 3), 0, 0, 0, 0);
        check(!nxt_valid_o, "R5", "current port not reused as next", int'(nxt_valid_o), 0);
        tick(bits3(3, 3, 3), 0, 0, 0, 1);
        check(cur_valid_o && cur_port_o == 3 && cur_credit_o == HUNGRY, "R3",
              "refreshed credit kept", int'(cur_credit_o), HUNGRY);

        // R5: round robin order after last granted port (3)
        tick('0, 1, 2, 0, 0);
        tick('0, 1, 20, 0, 0);
        tick('0, 1, 30, 0, 0);
        tick(bits3(2, 20, 30), 0, 0, 0, 0);
        check(nxt_valid_o && nxt_port_o == 20, "R5", "rr next", int'(nxt_port_o), 20);
        tick(bits3(2, 20, 30), 0, 0, 0, 1);
        check(cur_port_o == 20 && nxt_valid_o && nxt_port_o == 30, "R6",
              "rr after promote", int'(nxt_port_o), 30);
        tick(bits3(2, 20, 30), 0, 0, 0, 1);
        check(cur_port_o == 30 && nxt_valid_o && nxt_port_o == 2, "R5",
              "rr wrap", int'(nxt_port_o), 2);

        // constrained random phase against the model
        for (int n = 0; n < 4000; n++) begin
            bit [NP-1:0] rq;
            rq = ($urandom() | $urandom()) & ($urandom() | $urandom());
            tick(rq, ($urandom() % 10) < 6, int'($urandom() % NP),
                 int'($urandom() % 4), ($urandom() % 100) < 35);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule